// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This controller quiets one bus master port before the logic behind it is powered down. A one-cycle `start` pulse begins an attempt. The controller first looks at the port's idle indication. If the port is already idle, the attempt finishes at once and no halt is requested. Otherwise the controller raises `halt_req` and waits for the port to acknowledge.

The wait counts a free-running millisecond tick. The acknowledge is looked at only on a tick. The wait ends on the first tick that finds the acknowledge set, or after `TIMEOUT_MS` ticks, whichever comes first. The idle indication is then read once more. The attempt closes by dropping `halt_req` and pulsing `done` for one cycle, with `fail` set when the port is still not idle. The request is always withdrawn, even after a failure, because the port stays halted until it is reset.

Both port-side inputs pass through a two-flop synchronizer before any decision uses them. A change on either input therefore takes effect two clock cycles later.

Top module: `bus_halt_ctl`

## Requirements
- R1: After reset, `halt_req`, `done` and `fail` are all 0.
- R2: If `start` arrives while the synchronized idle input is 1, `done` pulses with `fail` = 0 and `halt_req` is never asserted for that attempt.
- R3: If `start` arrives while the synchronized idle input is 0, `halt_req` rises on the next cycle and stays at 1 for the whole wait.
- R4: The acknowledge input is acted on only in a cycle where `ms_tick` is 1. An acknowledge that rises and falls between ticks does not end the wait. The wait ends at the first tick that sees the acknowledge at 1.
- R5: If no tick sees the acknowledge, the wait ends at the `TIMEOUT_MS`-th tick after `halt_req` rose, and not earlier.
- R6: When a wait ends, `fail` is set to the inverse of the synchronized idle input sampled at that point, so 1 means the port did not become idle. `fail` holds its value until the next `done`.
- R7: `halt_req` falls in the same cycle that `done` rises, whether the attempt succeeded or failed.
- R8: `done` is 1 for exactly one cycle per attempt.
- R9: A `start` pulse that arrives while an attempt is in progress has no effect: it produces no extra `done` and does not move the end of the current attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a halt attempt |
| ms_tick | input | 1 | One-cycle pulse, once per millisecond |
| port_ack | input | 1 | Halt acknowledge from the port (asynchronous) |
| port_idle | input | 1 | Idle indication from the port (asynchronous) |
| halt_req | output | 1 | Halt request to the port |
| done | output | 1 | One-cycle pulse at the end of each attempt |
| fail | output | 1 | 1 if the port was not idle at the end of the last attempt |

## Verification
The bound assertions check the cycle-level contract on every cycle:
- `done` lasts one cycle.
- `halt_req` only rises after a `start` and only falls together with `done`.
- The number of ticks seen while `halt_req` is high never exceeds the timeout.
- `fail` changes only on `done`.

Only the bench scenarios can show the rest:
- The skip path when the port is already idle.
- The exact tick on which the wait ends, for every acknowledge arrival position and for the timeout.
- The mapping from the final idle sample to `fail`.
- That an acknowledge seen between ticks, or a `start` repeated during a wait, changes nothing.

// File: rtl/bus_halt_ctl.sv
module bus_halt_ctl #(
  parameter int TIMEOUT_MS  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ms_tick,
  input  logic port_ack,
  input  logic port_idle,
  output logic halt_req,
  output logic done,
  output logic fail
);

  localparam int CW = $clog2(TIMEOUT_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_MS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CHECK} state_t;

  state_t st;
  logic [CW-1:0] ticks;
  logic [SYNC_STAGES-1:0] ack_sh, idle_sh;

  wire ack_s  = ack_sh[SYNC_STAGES-1];
  wire idle_s = idle_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sh  <= '0;
      idle_sh <= '0;
    end else begin
      ack_sh  <= {ack_sh[SYNC_STAGES-2:0], port_ack};
      idle_sh <= {idle_sh[SYNC_STAGES-2:0], port_idle};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ticks    <= '0;
      halt_req <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (idle_s) begin
            done <= 1'b1;
            fail <= 1'b0;
          end else begin
            halt_req <= 1'b1;
            ticks    <= '0;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: if (ms_tick) begin
          if (ack_s || ticks == LAST) st <= ST_CHECK;
          else                        ticks <= ticks + 1'b1;
        end
        ST_CHECK: begin
          halt_req <= 1'b0;
          done     <= 1'b1;
          fail     <= ~idle_s;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_halt_ctl_checker.sv
module bus_halt_ctl_checker #(
  parameter int TIMEOUT_MS = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ms_tick,
  input logic halt_req,
  input logic done,
  input logic fail
);

  localparam int CW = $clog2(TIMEOUT_MS + 2);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= '0;
    else if (!halt_req) seen <= '0;
    else if (ms_tick)  seen <= seen + 1'b1;
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(start));

  p_req_drop_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> done);

  p_req_low_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !halt_req);

  p_wait_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (seen <= CW'(TIMEOUT_MS)));

  p_fail_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(fail));

endmodule

bind bus_halt_ctl bus_halt_ctl_checker #(.TIMEOUT_MS(TIMEOUT_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
  .halt_req(halt_req), .done(done), .fail(fail)
);

// File: tb/sim_bus_halt_ctl.sv
`timescale 1ns/1ps
module sim_bus_halt_ctl;
  localparam int T = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ms_tick = 1'b0;
  logic port_ack = 1'b0, port_idle = 1'b0;
  logic halt_req, done, fail;

  int nrun = 0, nfail = 0;
  int done_cnt = 0, req_rises = 0;
  logic last_fail = 1'b0, prev_req = 1'b0;

  always #5 clk = ~clk;

  bus_halt_ctl #(.TIMEOUT_MS(T)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
    .port_ack(port_ack), .port_idle(port_idle),
    .halt_req(halt_req), .done(done), .fail(fail)
  );

  always @(negedge clk) begin
    if (done) begin
      done_cnt <= done_cnt + 1;
      last_fail <= fail;
    end
    if (halt_req && !prev_req) req_rises <= req_rises + 1;
    prev_req <= halt_req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_tick;
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic clear_counts;
    cyc(1);
    done_cnt = 0;
    req_rises = 0;
  endtask

  // k = tick at which ack is first present (T+1: never), idle_end = idle at end
  task automatic trial(input int k, input bit idle_end, input bit extra_start);
    int last;
    last = (k <= T) ? k : T;
    port_ack = 1'b0;
    port_idle = 1'b0;
    cyc(5);
    clear_counts();
    pulse_start();
    cyc(4);
    chk(halt_req === 1'b1 && done_cnt == 0, "R3 req raised", halt_req, 1);
    port_idle = idle_end;
    for (int t = 1; t <= T + 1; t++) begin
      if (t == k) port_ack = 1'b1;
      if (extra_start && t == 1) pulse_start();
      cyc(4);
      pulse_tick();
      cyc(5);
      if (t < last) begin
        chk(done_cnt == 0 && halt_req === 1'b1, (k <= T) ? "R4 early end" : "R5 early end", done_cnt, 0);
      end else begin
        chk(done_cnt == 1, (k <= T) ? "R4 end tick" : "R5 timeout tick", done_cnt, 1);
        chk(last_fail === !idle_end, "R6 fail value", last_fail, !idle_end);
        chk(halt_req === 1'b0, "R7 req withdrawn", halt_req, 0);
        break;
      end
    end
    cyc(6);
    chk(done_cnt == 1, extra_start ? "R9 extra start" : "R8 single done", done_cnt, 1);
    port_ack = 1'b0;
  endtask

  initial begin
    #200000;
    nrun++; nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    cyc(3);
    chk(halt_req === 1'b0 && done === 1'b0 && fail === 1'b0, "R1 reset", {halt_req, done, fail}, 0);
    rst_n = 1'b1;
    cyc(3);

    // R2: already idle, with and without prior failure state
    for (int r = 0; r < 2; r++) begin
      port_idle = 1'b1;
      cyc(5);
      clear_counts();
      pulse_start();
      cyc(5);
      chk(done_cnt == 1, "R2 done count", done_cnt, 1);
      chk(last_fail === 1'b0, "R2 fail", last_fail, 0);
      chk(req_rises == 0, "R2 no request", req_rises, 0);
      if (r == 0) trial(T + 1, 1'b0, 1'b0);
    end

    // ticks without start do nothing
    clear_counts();
    for (int i = 0; i < 3; i++) pulse_tick();
    cyc(3);
    chk(done_cnt == 0 && halt_req === 1'b0, "R3 idle ticks", done_cnt, 0);

    // sweep ack position and final idle
    for (int k = 1; k <= T + 1; k++)
      for (int b = 0; b < 2; b++)
        trial(k, b[0], 1'b0);

    // R9: repeated start during wait
    trial(3, 1'b1, 1'b1);
    trial(T + 1, 1'b0, 1'b1);

    // R4: ack present only between ticks
    port_ack = 1'b0; port_idle = 1'b0;
    cyc(5);
    clear_counts();
    pulse_start();
    cyc(4);
    port_ack = 1'b1;
    cyc(4);
    port_ack = 1'b0;
    cyc(4);
    pulse_tick();
    cyc(5);
    chk(done_cnt == 0 && halt_req === 1'b1, "R4 ack between ticks", done_cnt, 0);
    for (int t = 2; t <= T; t++) pulse_tick();
    cyc(5);
    chk(done_cnt == 1 && last_fail === 1'b1, "R5 timeout after stray ack", done_cnt, 1);

    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule